// File: doc/BRIEF.md
# Register Use-Def Hazard Control Unit

This block decides, one request at a time, whether an instruction in an in-order multithreaded pipeline may take a source operand, commit a destination register, or reserve a destination. Each thread has its own dependency record. In that record, every register of every class (integer, floating-point, miscellaneous) holds an ordered list of the sequence numbers of its pending producers. A source read is answered from the register file, from the forwarding path, or with a stall. The block leaves the register storage and the execution units outside and only says which path applies. On a forward it also reports the sequence number of the producer to forward from.

Ahead of the register decision, the block enforces instruction ordering per thread. An instruction that must run alone waits until it is at the head of its thread. An instruction that serializes its successor arms a flag for the next younger request. A non-speculative instruction holds back every younger request of its thread until a graduate notice with a matching sequence number arrives. Three saturating counters tally register-file reads, register-file writes and forwarded reads.

Control is a two-state sequencer. `ST_IDLE` raises `req_ready`. The transition `IDLE->EVAL` is taken when `req_valid` is high, and the request is latched. `ST_EVAL` presents the response for exactly one cycle and commits any list, flag or counter change at the end of that cycle. The transition `EVAL->IDLE` is unconditional. A stalled request is simply issued again later by the pipeline.

Top module: `ud_hazard_ctrl`

## Requirements
- R1: `req_ready` is high when idle. A request accepted at a clock edge yields `rsp_valid` high for exactly the following cycle, during which `req_ready` is low. Every accepted request yields exactly one response.
- R2: Integer (class 0) register index 0 completes at once with `rsp_src`=0 (none), whatever the command. It records no producer, releases none and changes no counter.
- R3: A request with `req_fault` set, once past the head check, completes with `rsp_src`=0. It changes no list and no counter, even if it would otherwise stall on a dependency.
- R4: A read (`req_cmd`=0) with no pending producer older than its own sequence number completes with `rsp_src`=1 (file) and increments `cnt_rd`.
- R5: A read whose youngest older producer has signalled its result on the `res_*` port completes with `rsp_src`=2 (forward), `rsp_fwd_seq` equal to that producer's sequence number, and increments `cnt_fwd`. If that producer has not signalled, the read stalls (`rsp_done`=0).
- R6: A write (`req_cmd`=1) completes with `rsp_src`=1 only when its sequence number is the oldest pending producer of that register. It then removes that entry and increments `cnt_wr`. Otherwise it stalls.
- R7: A mark (`req_cmd`=2) appends its sequence number as the youngest producer of the named register and completes with `rsp_src`=0. When the list already holds 4 entries, it stalls and appends nothing.
- R8: Classes have separate index spaces (`req_cls` 0 integer, 1 floating-point, 2 miscellaneous). A producer in one class never affects the same index in another class.
- R9: A request with serialize-before or control-access set but `req_head` clear stalls. With `req_head` set it proceeds.
- R10: A serialize-after or store-conditional request arms its thread's pending flag and records its sequence number. The next request of that thread with a larger sequence number is treated as serialize-before. The flag clears when such a request passes the head check.
- R11: While a non-speculative request's sequence number is recorded as active, younger requests of its thread stall and older ones proceed. A graduate notice for that thread clears the active state only if its sequence number matches the recorded one.
- R12: `cnt_rd`, `cnt_wr` and `cnt_fwd` start at 0 after reset and stop at their all-ones value.
- R13: Dependency lists and ordering flags are per thread. State created by one thread never stalls another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_cmd | input | 2 | 0 read, 1 write, 2 mark, 3 no-op |
| req_tid | input | TID_W | Thread of the request |
| req_seq | input | SEQ_W | Sequence number of the instruction |
| req_cls | input | 2 | Register class: 0 int, 1 fp, 2 misc |
| req_idx | input | IDX_W | Register index within its class |
| req_head | input | 1 | Instruction is oldest in its thread |
| req_fault | input | 1 | Instruction carries a fault |
| req_ser_before | input | 1 | Serialize-before attribute |
| req_ser_after | input | 1 | Serialize-after attribute |
| req_ctrl_acc | input | 1 | Control-register access attribute |
| req_store_cond | input | 1 | Store-conditional attribute |
| req_nonspec | input | 1 | Non-speculative attribute |
| res_valid | input | 1 | A producer has its result |
| res_tid | input | TID_W | Thread of that producer |
| res_cls | input | 2 | Class of its destination |
| res_idx | input | IDX_W | Index of its destination |
| res_seq | input | SEQ_W | Sequence number of the producer |
| grad_valid | input | 1 | An instruction graduated |
| grad_tid | input | TID_W | Thread of the graduated instruction |
| grad_seq | input | SEQ_W | Sequence number of the graduated instruction |
| rsp_valid | output | 1 | Response present |
| rsp_done | output | 1 | 1 completed, 0 stalled |
| rsp_src | output | 2 | 0 none, 1 file, 2 forward |
| rsp_fwd_seq | output | SEQ_W | Producer to forward from (valid when rsp_src=2) |
| cnt_rd | output | CNT_W | Register-file read count |
| cnt_wr | output | CNT_W | Register-file write count |
| cnt_fwd | output | CNT_W | Forwarded read count |

## Verification
The response to a request driven before clock edge N is due in the cycle after edge N. The bench therefore samples it at the falling edge that follows, and a scoreboard queue pairs it with the expected item the driver pushed when it drove the request. List, flag and counter changes commit at edge N+1, so counters are read at the falling edge after that. A `res_*` or graduate pulse is driven for one cycle and takes effect at the next rising edge, before any later request is latched. Stall-then-retry pairs show both the blocked and the released outcome.

// File: rtl/ud_pkg.sv
package ud_pkg;

    localparam int NUM_CLS = 3;

    typedef enum logic [1:0] {
        CMD_READ  = 2'd0,
        CMD_WRITE = 2'd1,
        CMD_MARK  = 2'd2,
        CMD_NOP   = 2'd3
    } ud_cmd_e;

    typedef enum logic [1:0] {
        CLS_INT  = 2'd0,
        CLS_FP   = 2'd1,
        CLS_MISC = 2'd2,
        CLS_RSVD = 2'd3
    } ud_cls_e;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_FILE = 2'd1,
        SRC_FWD  = 2'd2,
        SRC_RSVD = 2'd3
    } ud_src_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EVAL = 1'b1
    } ud_state_e;

endpackage

// File: rtl/ud_tag_list.sv
module ud_tag_list #(
    parameter int SEQ_W = 16,
    parameter int DEPTH = 4,
    localparam int CNTL_W = $clog2(DEPTH + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          push_i,
    input  logic                          pop_i,
    input  logic [SEQ_W-1:0]              tag_i,
    input  logic                          rdy_set_i,
    input  logic [SEQ_W-1:0]              rdy_tag_i,
    output logic [DEPTH-1:0][SEQ_W-1:0]   tag_o,
    output logic [DEPTH-1:0]              rdy_o,
    output logic [CNTL_W-1:0]             cnt_o
);

    logic [DEPTH-1:0][SEQ_W-1:0] tag_q, tag_n;
    logic [DEPTH-1:0]            rdy_q, rdy_n;
    logic [CNTL_W-1:0]           cnt_q, cnt_n;

    always_comb begin
        tag_n = tag_q;
        rdy_n = rdy_q;
        cnt_n = cnt_q;
        if (pop_i) begin
            for (int j = 0; j < DEPTH - 1; j++) begin
                tag_n[j] = tag_q[j+1];
                rdy_n[j] = rdy_q[j+1];
            end
            tag_n[DEPTH-1] = '0;
            rdy_n[DEPTH-1] = 1'b0;
            cnt_n = cnt_q - 1'b1;
        end
        if (push_i) begin
            for (int j = 0; j < DEPTH; j++) begin
                if (CNTL_W'(j) == cnt_n) begin
                    tag_n[j] = tag_i;
                    rdy_n[j] = 1'b0;
                end
            end
            cnt_n = cnt_n + 1'b1;
        end
        if (rdy_set_i) begin
            for (int j = 0; j < DEPTH; j++) begin
                if (CNTL_W'(j) < cnt_n && tag_n[j] == rdy_tag_i) begin
                    rdy_n[j] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tag_q <= '0;
            rdy_q <= '0;
            cnt_q <= '0;
        end else begin
            tag_q <= tag_n;
            rdy_q <= rdy_n;
            cnt_q <= cnt_n;
        end
    end

    assign tag_o = tag_q;
    assign rdy_o = rdy_q;
    assign cnt_o = cnt_q;

    // R7: the controller never appends to a full list
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> cnt_q < CNTL_W'(DEPTH));

    // R6: the controller never releases from an empty list
    a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> cnt_q != '0);

endmodule

// File: rtl/ud_sat_cnt.sv
module ud_sat_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (inc_i && cnt_q != '1) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;

    // R12: once non-zero the count never wraps back to zero
    a_r12_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q != '0 |=> cnt_q != '0);

endmodule

// File: rtl/ud_thread_order.sv
module ud_thread_order #(
    parameter int SEQ_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEQ_W-1:0] seq_i,
    input  logic             set_ser_i,
    input  logic             clr_ser_i,
    input  logic             set_ns_i,
    input  logic             grad_i,
    input  logic [SEQ_W-1:0] grad_seq_i,
    output logic             ser_pend_o,
    output logic [SEQ_W-1:0] ser_seq_o,
    output logic             ns_act_o,
    output logic [SEQ_W-1:0] ns_seq_o
);

    logic             ser_pend_q, ns_act_q;
    logic [SEQ_W-1:0] ser_seq_q, ns_seq_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ser_pend_q <= 1'b0;
            ser_seq_q  <= '0;
        end else if (set_ser_i) begin
            ser_pend_q <= 1'b1;
            ser_seq_q  <= seq_i;
        end else if (clr_ser_i) begin
            ser_pend_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ns_act_q <= 1'b0;
            ns_seq_q <= '0;
        end else if (set_ns_i) begin
            ns_act_q <= 1'b1;
            ns_seq_q <= seq_i;
        end else if (grad_i && ns_act_q && grad_seq_i == ns_seq_q) begin
            ns_act_q <= 1'b0;
        end
    end

    assign ser_pend_o = ser_pend_q;
    assign ser_seq_o  = ser_seq_q;
    assign ns_act_o   = ns_act_q;
    assign ns_seq_o   = ns_seq_q;

    // R11: the recorded non-speculative number only changes on a new arrival
    a_r11_ns_seq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ns_act_q && !set_ns_i) |=> ns_seq_q == $past(ns_seq_q));

    // R11: a graduate with a different number leaves the active state alone
    a_r11_grad_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
        (ns_act_q && !set_ns_i && !(grad_i && grad_seq_i == ns_seq_q)) |=> ns_act_q);

    // R10: the armed serialize number is held until rearmed
    a_r10_ser_seq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_pend_q && !set_ser_i) |=> ser_seq_q == $past(ser_seq_q));

endmodule

// File: rtl/ud_hazard_ctrl.sv
module ud_hazard_ctrl
    import ud_pkg::*;
#(
    parameter int NTHR  = 2,
    parameter int NREG  = 8,
    parameter int SEQ_W = 16,
    parameter int DEPTH = 4,
    parameter int CNT_W = 16,
    localparam int TID_W = (NTHR > 1) ? $clog2(NTHR) : 1,
    localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [1:0]       req_cmd,
    input  logic [TID_W-1:0] req_tid,
    input  logic [SEQ_W-1:0] req_seq,
    input  logic [1:0]       req_cls,
    input  logic [IDX_W-1:0] req_idx,
    input  logic             req_head,
    input  logic             req_fault,
    input  logic             req_ser_before,
    input  logic             req_ser_after,
    input  logic             req_ctrl_acc,
    input  logic             req_store_cond,
    input  logic             req_nonspec,
    input  logic             res_valid,
    input  logic [TID_W-1:0] res_tid,
    input  logic [1:0]       res_cls,
    input  logic [IDX_W-1:0] res_idx,
    input  logic [SEQ_W-1:0] res_seq,
    input  logic             grad_valid,
    input  logic [TID_W-1:0] grad_tid,
    input  logic [SEQ_W-1:0] grad_seq,
    output logic             rsp_valid,
    output logic             rsp_done,
    output logic [1:0]       rsp_src,
    output logic [SEQ_W-1:0] rsp_fwd_seq,
    output logic [CNT_W-1:0] cnt_rd,
    output logic [CNT_W-1:0] cnt_wr,
    output logic [CNT_W-1:0] cnt_fwd
);

    localparam int NLIST  = NTHR * NUM_CLS * NREG;
    localparam int LIST_W = (NLIST > 1) ? $clog2(NLIST) : 1;
    localparam int CNTL_W = $clog2(DEPTH + 1);

    // ---------------------------------------------------------------
    // Sequencer state and latched request
    // ---------------------------------------------------------------
    ud_state_e        state_q, state_n;
    ud_cmd_e          r_cmd;
    ud_cls_e          r_cls;
    logic [TID_W-1:0] r_tid;
    logic [SEQ_W-1:0] r_seq;
    logic [IDX_W-1:0] r_idx;
    logic             r_head, r_fault, r_sb, r_sa, r_ctrl, r_sc, r_ns;

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_n = ST_EVAL;
            ST_EVAL: state_n = ST_IDLE;
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_cmd   <= CMD_NOP;
            r_cls   <= CLS_INT;
            r_tid   <= '0;
            r_seq   <= '0;
            r_idx   <= '0;
            r_head  <= 1'b0;
            r_fault <= 1'b0;
            r_sb    <= 1'b0;
            r_sa    <= 1'b0;
            r_ctrl  <= 1'b0;
            r_sc    <= 1'b0;
            r_ns    <= 1'b0;
        end else if (state_q == ST_IDLE && req_valid) begin
            r_cmd   <= ud_cmd_e'(req_cmd);
            r_cls   <= ud_cls_e'(req_cls);
            r_tid   <= req_tid;
            r_seq   <= req_seq;
            r_idx   <= req_idx;
            r_head  <= req_head;
            r_fault <= req_fault;
            r_sb    <= req_ser_before;
            r_sa    <= req_ser_after;
            r_ctrl  <= req_ctrl_acc;
            r_sc    <= req_store_cond;
            r_ns    <= req_nonspec;
        end
    end

    // ---------------------------------------------------------------
    // Per-thread ordering state
    // ---------------------------------------------------------------
    logic             set_ser, clr_ser, set_ns;
    logic             t_ser_pend [NTHR];
    logic [SEQ_W-1:0] t_ser_seq  [NTHR];
    logic             t_ns_act   [NTHR];
    logic [SEQ_W-1:0] t_ns_seq   [NTHR];

    for (genvar gt = 0; gt < NTHR; gt++) begin : g_thr
        logic mine;
        assign mine = (r_tid == TID_W'(gt));
        ud_thread_order #(.SEQ_W(SEQ_W)) u_order (
            .clk        (clk),
            .rst_n      (rst_n),
            .seq_i      (r_seq),
            .set_ser_i  (set_ser && mine),
            .clr_ser_i  (clr_ser && mine),
            .set_ns_i   (set_ns && mine),
            .grad_i     (grad_valid && grad_tid == TID_W'(gt)),
            .grad_seq_i (grad_seq),
            .ser_pend_o (t_ser_pend[gt]),
            .ser_seq_o  (t_ser_seq[gt]),
            .ns_act_o   (t_ns_act[gt]),
            .ns_seq_o   (t_ns_seq[gt])
        );
    end

    // ---------------------------------------------------------------
    // Dependency lists, one per (thread, class, register)
    // ---------------------------------------------------------------
    logic                        do_push, do_pop;
    logic [LIST_W-1:0]           sel_list, res_list;
    logic                        sel_ok, res_ok;
    logic [DEPTH-1:0][SEQ_W-1:0] l_tag [NLIST];
    logic [DEPTH-1:0]            l_rdy [NLIST];
    logic [CNTL_W-1:0]           l_cnt [NLIST];

    assign sel_ok   = (r_cls != CLS_RSVD);
    assign sel_list = LIST_W'((int'(r_tid) * NUM_CLS + int'(r_cls)) * NREG + int'(r_idx));
    assign res_ok   = (res_cls != 2'd3);
    assign res_list = LIST_W'((int'(res_tid) * NUM_CLS + int'(res_cls)) * NREG + int'(res_idx));

    for (genvar gl = 0; gl < NLIST; gl++) begin : g_list
        ud_tag_list #(.SEQ_W(SEQ_W), .DEPTH(DEPTH)) u_list (
            .clk       (clk),
            .rst_n     (rst_n),
            .push_i    (do_push && sel_list == LIST_W'(gl)),
            .pop_i     (do_pop && sel_list == LIST_W'(gl)),
            .tag_i     (r_seq),
            .rdy_set_i (res_valid && res_ok && res_list == LIST_W'(gl)),
            .rdy_tag_i (res_seq),
            .tag_o     (l_tag[gl]),
            .rdy_o     (l_rdy[gl]),
            .cnt_o     (l_cnt[gl])
        );
    end

    // ---------------------------------------------------------------
    // Decision for the latched request
    // ---------------------------------------------------------------
    logic [DEPTH-1:0][SEQ_W-1:0] cur_tag;
    logic [DEPTH-1:0]            cur_rdy;
    logic [CNTL_W-1:0]           cur_cnt;
    logic                        cur_ser_pend, cur_ns_act, ser_hit, r_zero;
    logic [SEQ_W-1:0]            cur_ser_seq, cur_ns_seq;
    logic                        found, f_rdy, stall;
    logic [SEQ_W-1:0]            f_tag, fwd_seq;
    ud_src_e                     src;
    logic                        inc_rd, inc_wr, inc_fwd;

    assign cur_tag      = l_tag[sel_list];
    assign cur_rdy      = l_rdy[sel_list];
    assign cur_cnt      = l_cnt[sel_list];
    assign cur_ser_pend = t_ser_pend[r_tid];
    assign cur_ser_seq  = t_ser_seq[r_tid];
    assign cur_ns_act   = t_ns_act[r_tid];
    assign cur_ns_seq   = t_ns_seq[r_tid];
    assign ser_hit      = cur_ser_pend && (r_seq > cur_ser_seq);
    assign r_zero       = (r_cls == CLS_INT) && (r_idx == '0);

    always_comb begin
        found = 1'b0;
        f_tag = '0;
        f_rdy = 1'b0;
        for (int j = 0; j < DEPTH; j++) begin
            if (CNTL_W'(j) < cur_cnt && cur_tag[j] < r_seq) begin
                found = 1'b1;
                f_tag = cur_tag[j];
                f_rdy = cur_rdy[j];
            end
        end
    end

    always_comb begin
        stall   = 1'b0;
        src     = SRC_NONE;
        fwd_seq = '0;
        do_push = 1'b0;
        do_pop  = 1'b0;
        set_ser = 1'b0;
        clr_ser = 1'b0;
        set_ns  = 1'b0;
        inc_rd  = 1'b0;
        inc_wr  = 1'b0;
        inc_fwd = 1'b0;
        if (state_q == ST_EVAL) begin
            if ((r_sb || ser_hit || r_ctrl) && !r_head) begin
                stall = 1'b1;
            end else begin
                clr_ser = ser_hit;
                set_ser = r_sa || r_sc;
                if (r_fault) begin
                    src = SRC_NONE;
                end else if (cur_ns_act && r_seq > cur_ns_seq) begin
                    stall = 1'b1;
                end else begin
                    set_ns = r_ns;
                    if (!r_zero && sel_ok) begin
                        unique case (r_cmd)
                            CMD_READ: begin
                                if (!found) begin
                                    src    = SRC_FILE;
                                    inc_rd = 1'b1;
                                end else if (f_rdy) begin
                                    src     = SRC_FWD;
                                    fwd_seq = f_tag;
                                    inc_fwd = 1'b1;
                                end else begin
                                    stall = 1'b1;
                                end
                            end
                            CMD_WRITE: begin
                                if (cur_cnt != '0 && cur_tag[0] == r_seq) begin
                                    src    = SRC_FILE;
                                    do_pop = 1'b1;
                                    inc_wr = 1'b1;
                                end else begin
                                    stall = 1'b1;
                                end
                            end
                            CMD_MARK: begin
                                if (cur_cnt == CNTL_W'(DEPTH)) begin
                                    stall = 1'b1;
                                end else begin
                                    do_push = 1'b1;
                                end
                            end
                            default: src = SRC_NONE;
                        endcase
                    end
                end
            end
        end
    end

    // ---------------------------------------------------------------
    // Outputs
    // ---------------------------------------------------------------
    always_comb begin
        req_ready   = (state_q == ST_IDLE);
        rsp_valid   = (state_q == ST_EVAL);
        rsp_done    = (state_q == ST_EVAL) && !stall;
        rsp_src     = src;
        rsp_fwd_seq = fwd_seq;
    end

    ud_sat_cnt #(.W(CNT_W)) u_cnt_rd  (.clk(clk), .rst_n(rst_n), .inc_i(inc_rd),  .cnt_o(cnt_rd));
    ud_sat_cnt #(.W(CNT_W)) u_cnt_wr  (.clk(clk), .rst_n(rst_n), .inc_i(inc_wr),  .cnt_o(cnt_wr));
    ud_sat_cnt #(.W(CNT_W)) u_cnt_fwd (.clk(clk), .rst_n(rst_n), .inc_i(inc_fwd), .cnt_o(cnt_fwd));

    // R1: a response lasts one cycle and the block is ready again after it
    a_r1_single_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (req_ready && !rsp_valid));

    // R1: a request seen while ready is answered in the next cycle
    a_r1_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid) |=> rsp_valid);

    // R5: a forward is a completion from an older producer
    a_r5_fwd_older: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_src == SRC_FWD) |-> (rsp_done && rsp_fwd_seq < r_seq));

    // R9: an ordering-restricted request off the head never completes
    a_r9_head_block: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (r_sb || r_ctrl) && !r_head) |-> !rsp_done);

    // R2: the integer zero register never uses a data path
    a_r2_zero_none: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && r_zero) |-> rsp_src == SRC_NONE);

    // R3: a faulted request never uses a data path
    a_r3_fault_none: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && r_fault) |-> rsp_src == SRC_NONE);

endmodule

// File: tb/ud_hazard_ctrl_bench.sv
`timescale 1ns/1ps
module ud_hazard_ctrl_bench;

    localparam int NTHR  = 2;
    localparam int NREG  = 8;
    localparam int SEQ_W = 16;
    localparam int DEPTH = 4;
    localparam int CNT_W = 4;
    localparam int CMAX  = (1 << CNT_W) - 1;

    localparam int RD = 0, WR = 1, MK = 2;
    localparam int CI = 0, CF = 1;
    localparam int NONE = 0, FILE = 1, FWD = 2;
    localparam int A_HEAD = 1, A_FAULT = 2, A_SB = 4, A_SA = 8, A_CTRL = 16, A_SC = 32, A_NS = 64;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [1:0]       req_cmd = '0;
    logic [0:0]       req_tid = '0;
    logic [SEQ_W-1:0] req_seq = '0;
    logic [1:0]       req_cls = '0;
    logic [2:0]       req_idx = '0;
    logic             req_head = 0, req_fault = 0, req_ser_before = 0, req_ser_after = 0;
    logic             req_ctrl_acc = 0, req_store_cond = 0, req_nonspec = 0;
    logic             res_valid = 1'b0;
    logic [0:0]       res_tid = '0;
    logic [1:0]       res_cls = '0;
    logic [2:0]       res_idx = '0;
    logic [SEQ_W-1:0] res_seq = '0;
    logic             grad_valid = 1'b0;
    logic [0:0]       grad_tid = '0;
    logic [SEQ_W-1:0] grad_seq = '0;
    logic             rsp_valid, rsp_done;
    logic [1:0]       rsp_src;
    logic [SEQ_W-1:0] rsp_fwd_seq;
    logic [CNT_W-1:0] cnt_rd, cnt_wr, cnt_fwd;

    always #10 clk = ~clk;

    ud_hazard_ctrl #(.NTHR(NTHR), .NREG(NREG), .SEQ_W(SEQ_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_ud_hazard_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_cmd(req_cmd), .req_tid(req_tid),
        .req_seq(req_seq), .req_cls(req_cls), .req_idx(req_idx), .req_head(req_head),
        .req_fault(req_fault), .req_ser_before(req_ser_before), .req_ser_after(req_ser_after),
        .req_ctrl_acc(req_ctrl_acc), .req_store_cond(req_store_cond), .req_nonspec(req_nonspec),
        .res_valid(res_valid), .res_tid(res_tid), .res_cls(res_cls), .res_idx(res_idx), .res_seq(res_seq),
        .grad_valid(grad_valid), .grad_tid(grad_tid), .grad_seq(grad_seq),
        .rsp_valid(rsp_valid), .rsp_done(rsp_done), .rsp_src(rsp_src), .rsp_fwd_seq(rsp_fwd_seq),
        .cnt_rd(cnt_rd), .cnt_wr(cnt_wr), .cnt_fwd(cnt_fwd)
    );

    int checks = 0;
    int errors = 0;
    int exp_rd = 0, exp_wr = 0, exp_fwd = 0;
    logic [SEQ_W+2:0] exp_q[$];
    string            tag_q[$];

    task automatic check_eq(input string rq, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    function automatic int sat(input int v);
        return (v >= CMAX) ? CMAX : v + 1;
    endfunction

    // Driver: one request, expected response pushed onto the scoreboard
    task automatic issue(input int cmd, input int tid, input int seq, input int cls, input int idx,
                         input int attr, input int e_done, input int e_src, input int e_fwd,
                         input string rq);
        @(negedge clk);
        check_eq("R1", "ready while idle", int'(req_ready), 1);
        req_cmd = 2'(cmd); req_tid = 1'(tid); req_seq = SEQ_W'(seq);
        req_cls = 2'(cls); req_idx = 3'(idx);
        req_head       = (attr & A_HEAD) != 0;
        req_fault      = (attr & A_FAULT) != 0;
        req_ser_before = (attr & A_SB) != 0;
        req_ser_after  = (attr & A_SA) != 0;
        req_ctrl_acc   = (attr & A_CTRL) != 0;
        req_store_cond = (attr & A_SC) != 0;
        req_nonspec    = (attr & A_NS) != 0;
        req_valid = 1'b1;
        exp_q.push_back({1'(e_done), 2'(e_src), SEQ_W'(e_fwd)});
        tag_q.push_back(rq);
        if (e_done != 0) begin
            if (cmd == RD && e_src == FILE) exp_rd = sat(exp_rd);
            if (cmd == RD && e_src == FWD)  exp_fwd = sat(exp_fwd);
            if (cmd == WR && e_src == FILE) exp_wr = sat(exp_wr);
        end
        @(negedge clk);
        req_valid = 1'b0;
        check_eq("R1", "ready low while responding", int'(req_ready), 0);
        @(negedge clk);
    endtask

    task automatic produce(input int tid, input int cls, input int idx, input int seq);
        @(negedge clk);
        res_tid = 1'(tid); res_cls = 2'(cls); res_idx = 3'(idx); res_seq = SEQ_W'(seq);
        res_valid = 1'b1;
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    task automatic graduate(input int tid, input int seq);
        @(negedge clk);
        grad_tid = 1'(tid); grad_seq = SEQ_W'(seq);
        grad_valid = 1'b1;
        @(negedge clk);
        grad_valid = 1'b0;
    endtask

    task automatic check_counts(input string rq);
        check_eq(rq, "cnt_rd", int'(cnt_rd), exp_rd);
        check_eq(rq, "cnt_wr", int'(cnt_wr), exp_wr);
        check_eq(rq, "cnt_fwd", int'(cnt_fwd), exp_fwd);
    endtask

    // Monitor: pops the scoreboard whenever a response appears
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R1 unexpected response: actual 1 expected 0");
            end else begin
                logic [SEQ_W+2:0] e;
                string rq;
                e  = exp_q.pop_front();
                rq = tag_q.pop_front();
                check_eq(rq, "rsp_done", int'(rsp_done), int'(e[SEQ_W+2]));
                check_eq(rq, "rsp_src", int'(rsp_src), int'(e[SEQ_W+1:SEQ_W]));
                if (e[SEQ_W+1:SEQ_W] == 2'(FWD))
                    check_eq(rq, "rsp_fwd_seq", int'(rsp_fwd_seq), int'(e[SEQ_W-1:0]));
            end
        end
    end

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 / R12: reset state
        check_eq("R1", "ready after reset", int'(req_ready), 1);
        check_eq("R1", "no response after reset", int'(rsp_valid), 0);
        check_counts("R12");

        // R4: plain read from the file
        issue(RD, 0, 10, CI, 1, 0, 1, FILE, 0, "R4");
        check_eq("R4", "cnt_rd after file read", int'(cnt_rd), 1);

        // R2: integer zero register in every command
        issue(RD, 0, 11, CI, 0, 0, 1, NONE, 0, "R2");
        issue(MK, 0, 12, CI, 0, 0, 1, NONE, 0, "R2");
        issue(RD, 0, 13, CI, 0, 0, 1, NONE, 0, "R2");
        issue(WR, 0, 12, CI, 0, 0, 1, NONE, 0, "R2");
        check_counts("R2");

        // R5 / R7: mark, stall on unproduced result, then forward
        issue(MK, 0, 20, CI, 2, 0, 1, NONE, 0, "R7");
        issue(RD, 0, 21, CI, 2, 0, 0, NONE, 0, "R5");
        produce(0, CI, 2, 20);
        issue(RD, 0, 21, CI, 2, 0, 1, FWD, 20, "R5");
        issue(RD, 0, 19, CI, 2, 0, 1, FILE, 0, "R4");
        issue(MK, 0, 25, CI, 2, 0, 1, NONE, 0, "R7");
        issue(RD, 0, 30, CI, 2, 0, 0, NONE, 0, "R5");
        produce(0, CI, 2, 25);
        issue(RD, 0, 30, CI, 2, 0, 1, FWD, 25, "R5");
        issue(RD, 0, 22, CI, 2, 0, 1, FWD, 20, "R5");

        // R6: write order follows producer order
        issue(WR, 0, 25, CI, 2, 0, 0, NONE, 0, "R6");
        issue(WR, 0, 20, CI, 2, 0, 1, FILE, 0, "R6");
        issue(WR, 0, 25, CI, 2, 0, 1, FILE, 0, "R6");
        issue(RD, 0, 30, CI, 2, 0, 1, FILE, 0, "R6");
        check_counts("R6");

        // R8 / R13: classes and threads are separate
        issue(MK, 0, 40, CF, 2, 0, 1, NONE, 0, "R8");
        issue(RD, 0, 41, CI, 2, 0, 1, FILE, 0, "R8");
        issue(RD, 0, 41, CF, 2, 0, 0, NONE, 0, "R8");
        issue(RD, 1, 41, CF, 2, 0, 1, FILE, 0, "R13");
        issue(WR, 0, 40, CF, 2, 0, 1, FILE, 0, "R8");

        // R7: list depth limit
        for (int k = 0; k < DEPTH; k++)
            issue(MK, 0, 50 + k, CI, 3, 0, 1, NONE, 0, "R7");
        issue(MK, 0, 54, CI, 3, 0, 0, NONE, 0, "R7");
        issue(WR, 0, 50, CI, 3, 0, 1, FILE, 0, "R7");
        issue(MK, 0, 54, CI, 3, 0, 1, NONE, 0, "R7");

        // R3: fault skips the dependency that would stall it
        issue(RD, 0, 60, CI, 3, A_FAULT, 1, NONE, 0, "R3");
        issue(MK, 0, 61, CI, 4, A_FAULT, 1, NONE, 0, "R3");
        issue(RD, 0, 62, CI, 4, 0, 1, FILE, 0, "R3");
        check_counts("R3");

        // R9: head requirement
        issue(RD, 0, 70, CI, 1, A_SB, 0, NONE, 0, "R9");
        issue(RD, 0, 70, CI, 1, A_SB | A_HEAD, 1, FILE, 0, "R9");
        issue(RD, 0, 71, CI, 1, A_CTRL, 0, NONE, 0, "R9");
        issue(RD, 0, 71, CI, 1, A_CTRL | A_HEAD, 1, FILE, 0, "R9");

        // R10: serialize-after arms the next younger request
        issue(RD, 0, 80, CI, 1, A_SA, 1, FILE, 0, "R10");
        issue(RD, 0, 81, CI, 1, 0, 0, NONE, 0, "R10");
        issue(RD, 1, 82, CI, 1, 0, 1, FILE, 0, "R13");
        issue(RD, 0, 81, CI, 1, A_HEAD, 1, FILE, 0, "R10");
        issue(RD, 0, 82, CI, 1, 0, 1, FILE, 0, "R10");
        issue(RD, 0, 83, CI, 1, A_SC, 1, FILE, 0, "R10");
        issue(RD, 0, 84, CI, 1, 0, 0, NONE, 0, "R10");
        issue(RD, 0, 84, CI, 1, A_HEAD, 1, FILE, 0, "R10");

        // R11: non-speculative hold and matching graduate
        issue(RD, 0, 90, CI, 1, A_NS, 1, FILE, 0, "R11");
        issue(RD, 0, 91, CI, 1, 0, 0, NONE, 0, "R11");
        issue(RD, 0, 89, CI, 1, 0, 1, FILE, 0, "R11");
        issue(RD, 1, 95, CI, 1, 0, 1, FILE, 0, "R13");
        graduate(0, 77);
        issue(RD, 0, 91, CI, 1, 0, 0, NONE, 0, "R11");
        graduate(0, 90);
        issue(RD, 0, 91, CI, 1, 0, 1, FILE, 0, "R11");
        check_counts("R11");

        // R12: saturation
        for (int k = 0; k < CMAX; k++)
            issue(RD, 0, 100 + k, CI, 5, 0, 1, FILE, 0, "R12");
        check_counts("R12");
        check_eq("R12", "cnt_rd saturated", int'(cnt_rd), CMAX);

        repeat (2) @(negedge clk);
        check_eq("R1", "responses outstanding", exp_q.size(), 0);
        finish_run();
    end

endmodule